// File: doc/BRIEF.md
# Reference and Feedback Divider Pair

This block divides two unrelated clocks by programmable moduli. The reference lane counts on `ref_clk` and divides by `ref_mod`. The feedback lane counts on `fb_clk` and divides by `fb_mod`. Each lane contains a down-counter that produces a one-cycle terminal-count strobe once per modulus period. Each lane also has a toggle stage that flips on every strobe. The toggle output runs at half the strobe rate with an exact 50% duty cycle. A select word routes either half-rate signal to a single monitor output, which is used for bench measurements of each divider.

Two controls stop both lanes at their load value:

- a software hold bit (`hold_ctl`);
- a hold request from power control (`pwr_hold`).

Each hold is OR-ed, then resynchronized separately into each clock domain. On release, both lanes start from a freshly loaded count. Because the lanes use synchronizers of equal depth, they restart in step when their clocks run at the same rate.

Top module: `div_pair_core`

## Requirements
- R1: While running with a modulus M of 2 or more, a lane's terminal-count strobe is high for exactly one cycle out of every M cycles of its own clock.
- R2: A modulus of 0 or of 1 both divide by one. While running, the strobe is then high on every cycle.
- R3: A new modulus written while a lane is counting does not shorten or stretch the current period. It is first used at the next reload.
- R4: A lane's half-rate output inverts on the clock edge that ends each strobe cycle, and is otherwise unchanged while running. With modulus M it is high for M cycles and low for M cycles.
- R5: While `hold_ctl` is 1 (after synchronization), both lanes keep their counters at the load value, their strobes stay 0 and their half-rate outputs are 0.
- R6: `pwr_hold` has the same effect as `hold_ctl`; either one alone holds both lanes.
- R7: A hold change passes through SYNC_STAGES flops in each domain. After release, a lane with modulus M raises its first strobe just after edge SYNC_STAGES+M-1, counted from the first edge that samples the release.
- R8: `mon_sel` = 1 routes the reference half-rate output to `mon_out`. `mon_sel` = 2 routes the feedback half-rate output. Every other value drives `mon_out` to 0.
- R9: A clock edge with `rst_n` low puts that lane in the held state: strobe 0, half-rate output 0, synchronizer showing a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference-lane clock |
| fb_clk | input | 1 | Feedback-lane clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| hold_ctl | input | 1 | Software counter-hold bit |
| pwr_hold | input | 1 | Hold request from power control |
| ref_mod | input | DIV_W | Reference divide modulus |
| fb_mod | input | DIV_W | Feedback divide modulus |
| mon_sel | input | 3 | Monitor source select |
| ref_tc | output | 1 | Reference terminal-count strobe |
| fb_tc | output | 1 | Feedback terminal-count strobe |
| ref_half | output | 1 | Reference half-rate, 50% duty output |
| fb_half | output | 1 | Feedback half-rate, 50% duty output |
| mon_out | output | 1 | Shared monitor output |

## Verification
Each strobe is decoded from the count register, so it is valid in the cycle that follows the edge loading that count. Each half-rate output changes on the edge that closes a strobe cycle. The monitor follows `mon_sel` and the half-rate outputs within the same cycle. Hold and release take effect SYNC_STAGES edges later in each domain, and the first strobe after release appears SYNC_STAGES+M-1 edges after the release is sampled.

The bench drives inputs on falling reference edges. It samples each lane two nanoseconds after that lane's own rising edge, and the two clock periods are chosen so those instants never coincide with an edge of the other domain. A cycle-level expectation per domain is stepped on the same edges, and directed measurements count edges to the first strobe and between strobes.

// File: rtl/div_pair_pkg.sv
// Shared constants and types for the divider pair.
// Assumes two lanes: index 0 is the reference lane, index 1 the feedback lane.
package div_pair_pkg;

    localparam int LANES     = 2;
    localparam int LANE_REF  = 0;
    localparam int LANE_FB   = 1;
    localparam int MON_SEL_W = 3;

    // Monitor source codes; any value not listed selects a constant 0.
    typedef enum logic [MON_SEL_W-1:0] {
        MON_OFF      = 3'd0,
        MON_REF_HALF = 3'd1,
        MON_FB_HALF  = 3'd2
    } mon_sel_e;

endpackage

// File: rtl/div_pair_sync.sv
// Multi-flop resynchronizer for a level hold request.
// Does: carries an asynchronous level into the clk domain through STAGES flops.
// Assumes: the input is a slow level; reset forces the output to 1 (held).
module div_pair_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop, reset to the held level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= async_in;
            end
        end else begin : g_multi
            // Purpose: shift the request through the flop chain, reset to held.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/div_pair_lane.sv
// One divider lane: programmable down-counter plus half-rate toggle.
// Does: counts modulus-1 down to 0, strobes at 0, reloads, toggles half.
// Assumes: hold is already synchronous to clk; modulus 0 acts as modulus 1;
// modulus is read only when the counter loads (hold or terminal count).
module div_pair_lane #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] modulus,
    output logic             tc,
    output logic             half
);

    localparam logic [DIV_W-1:0] ONE  = {{(DIV_W-1){1'b0}}, 1'b1};
    localparam logic [DIV_W-1:0] ZERO = '0;

    logic [DIV_W-1:0] load_val;
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    // Purpose: derive the load point, mapping modulus 0 to divide-by-one.
    always_comb begin
        if (modulus == ZERO) load_val = ZERO;
        else                 load_val = modulus - ONE;
    end

    assign at_end = (cnt == ZERO);

    // Purpose: hold at load point, or count down and reload at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt  <= load_val;
            half <= 1'b0;
        end else if (at_end) begin
            cnt  <= load_val;
            half <= ~half;
        end else begin
            cnt  <= cnt - ONE;
        end
    end

    assign tc = at_end && !hold;

endmodule

// File: rtl/div_pair_mon.sv
// Monitor multiplexer for the half-rate taps.
// Does: routes one half-rate lane output to a shared pin.
// Assumes: unassigned select codes must give a steady 0.
module div_pair_mon
    import div_pair_pkg::*;
(
    input  logic [MON_SEL_W-1:0] sel,
    input  logic                 ref_half,
    input  logic                 fb_half,
    output logic                 mon_out
);

    // Purpose: decode the select word into the monitor level.
    always_comb begin
        case (sel)
            MON_REF_HALF: mon_out = ref_half;
            MON_FB_HALF:  mon_out = fb_half;
            default:      mon_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/div_pair_core.sv
// Reference/feedback divider pair, top level.
// Does: merges both hold sources, resynchronizes them per lane, runs two
// divider lanes on their own clocks and selects a half-rate monitor tap.
// Assumes: rst_n is held low for several edges of both clocks.
module div_pair_core
    import div_pair_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 ref_clk,
    input  logic                 fb_clk,
    input  logic                 rst_n,
    input  logic                 hold_ctl,
    input  logic                 pwr_hold,
    input  logic [DIV_W-1:0]     ref_mod,
    input  logic [DIV_W-1:0]     fb_mod,
    input  logic [MON_SEL_W-1:0] mon_sel,
    output logic                 ref_tc,
    output logic                 fb_tc,
    output logic                 ref_half,
    output logic                 fb_half,
    output logic                 mon_out
);

    logic             hold_req;
    logic [LANES-1:0] lane_clk;
    logic [DIV_W-1:0] lane_mod [LANES];
    logic [LANES-1:0] lane_hold;
    logic [LANES-1:0] lane_tc;
    logic [LANES-1:0] lane_half;

    assign hold_req           = hold_ctl | pwr_hold;
    assign lane_clk[LANE_REF] = ref_clk;
    assign lane_clk[LANE_FB]  = fb_clk;
    assign lane_mod[LANE_REF] = ref_mod;
    assign lane_mod[LANE_FB]  = fb_mod;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            div_pair_sync #(
                .STAGES   (SYNC_STAGES)
            ) u_sync (
                .clk      (lane_clk[g]),
                .rst_n    (rst_n),
                .async_in (hold_req),
                .sync_out (lane_hold[g])
            );

            div_pair_lane #(
                .DIV_W    (DIV_W)
            ) u_lane (
                .clk      (lane_clk[g]),
                .rst_n    (rst_n),
                .hold     (lane_hold[g]),
                .modulus  (lane_mod[g]),
                .tc       (lane_tc[g]),
                .half     (lane_half[g])
            );
        end
    endgenerate

    div_pair_mon u_mon (
        .sel      (mon_sel),
        .ref_half (lane_half[LANE_REF]),
        .fb_half  (lane_half[LANE_FB]),
        .mon_out  (mon_out)
    );

    assign ref_tc   = lane_tc[LANE_REF];
    assign fb_tc    = lane_tc[LANE_FB];
    assign ref_half = lane_half[LANE_REF];
    assign fb_half  = lane_half[LANE_FB];

endmodule

// File: rtl/div_pair_core_chk.sv
// Property checker for div_pair_core, attached by bind.
// Does: checks strobe width, toggle behaviour, hold effect, release timing
// for divide-by-one, and monitor routing.
module div_pair_core_chk #(
    parameter int DIV_W = 8
) (
    input logic             ref_clk,
    input logic             fb_clk,
    input logic             rst_n,
    input logic             ref_hold_s,
    input logic             fb_hold_s,
    input logic [DIV_W-1:0] ref_mod,
    input logic [DIV_W-1:0] fb_mod,
    input logic [2:0]       mon_sel,
    input logic             ref_tc,
    input logic             fb_tc,
    input logic             ref_half,
    input logic             fb_half,
    input logic             mon_out
);

    assert_ref_tc_single_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_tc && ref_mod > 1) |=> !ref_tc);
    assert_fb_tc_single_R1: assert property (@(posedge fb_clk) disable iff (!rst_n)
        (fb_tc && fb_mod > 1) |=> !fb_tc);

    assert_ref_first_tc_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($fell(ref_hold_s) && $past(ref_mod) <= 1) |-> ref_tc);

    assert_ref_half_flip_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_tc |=> (ref_half != $past(ref_half)));
    assert_ref_half_quiet_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!ref_tc && !ref_hold_s) |=> $stable(ref_half));
    assert_fb_half_flip_R4: assert property (@(posedge fb_clk) disable iff (!rst_n)
        fb_tc |=> (fb_half != $past(fb_half)));

    assert_ref_hold_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_hold_s |-> !ref_tc);
    assert_ref_hold_half_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_hold_s |=> !ref_half);
    assert_fb_hold_R5: assert property (@(posedge fb_clk) disable iff (!rst_n)
        fb_hold_s |-> !fb_tc);

    assert_mon_off_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mon_sel != 3'd1 && mon_sel != 3'd2) |-> !mon_out);
    assert_mon_ref_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mon_sel == 3'd1) |-> (mon_out == ref_half));

endmodule

bind div_pair_core div_pair_core_chk #(
    .DIV_W      (DIV_W)
) u_chk (
    .ref_clk    (ref_clk),
    .fb_clk     (fb_clk),
    .rst_n      (rst_n),
    .ref_hold_s (lane_hold[0]),
    .fb_hold_s  (lane_hold[1]),
    .ref_mod    (ref_mod),
    .fb_mod     (fb_mod),
    .mon_sel    (mon_sel),
    .ref_tc     (ref_tc),
    .fb_tc      (fb_tc),
    .ref_half   (ref_half),
    .fb_half    (fb_half),
    .mon_out    (mon_out)
);

// File: tb/test_div_pair_core.sv
// Bench for div_pair_core: per-domain expectation plus directed corner cases.
module test_div_pair_core;

    localparam int DIV_W = 8;
    localparam int SYNC  = 2;

    logic             ref_clk = 1'b0;
    logic             fb_clk  = 1'b0;
    logic             rst_n   = 1'b0;
    logic             hold_ctl = 1'b0;
    logic             pwr_hold = 1'b0;
    logic [DIV_W-1:0] ref_mod = 8'd5;
    logic [DIV_W-1:0] fb_mod  = 8'd3;
    logic [2:0]       mon_sel = 3'd0;
    logic             ref_tc, fb_tc, ref_half, fb_half, mon_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  chk_en = 1'b0;
    bit  done   = 1'b0;

    // 125 MHz reference clock (rising at 4+8k ns), feedback clock at 100 MHz.
    always #4 ref_clk = ~ref_clk;
    always #5 fb_clk  = ~fb_clk;

    div_pair_core #(
        .DIV_W       (DIV_W),
        .SYNC_STAGES (SYNC)
    ) i_div_pair_core (
        .ref_clk  (ref_clk),
        .fb_clk   (fb_clk),
        .rst_n    (rst_n),
        .hold_ctl (hold_ctl),
        .pwr_hold (pwr_hold),
        .ref_mod  (ref_mod),
        .fb_mod   (fb_mod),
        .mon_sel  (mon_sel),
        .ref_tc   (ref_tc),
        .fb_tc    (fb_tc),
        .ref_half (ref_half),
        .fb_half  (fb_half),
        .mon_out  (mon_out)
    );

    function automatic logic [DIV_W-1:0] f_load(input logic [DIV_W-1:0] m);
        return (m == '0) ? '0 : m - 1'b1;
    endfunction

    function automatic logic f_mon(input logic [2:0] s, input logic a, input logic b);
        if (s == 3'd1) return a;
        if (s == 3'd2) return b;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected state per domain, stepped on the same edges as the design.
    logic [SYNC-1:0]  e_rsync, e_fsync;
    logic [DIV_W-1:0] e_rcnt, e_fcnt;
    logic             e_rtog, e_ftog;

    always @(posedge ref_clk) begin
        if (!rst_n) begin
            e_rsync <= '1; e_rcnt <= f_load(ref_mod); e_rtog <= 1'b0;
        end else begin
            e_rsync <= {e_rsync[SYNC-2:0], hold_ctl | pwr_hold};
            if (e_rsync[SYNC-1]) begin
                e_rcnt <= f_load(ref_mod); e_rtog <= 1'b0;
            end else if (e_rcnt == '0) begin
                e_rcnt <= f_load(ref_mod); e_rtog <= ~e_rtog;
            end else e_rcnt <= e_rcnt - 1'b1;
        end
    end

    always @(posedge fb_clk) begin
        if (!rst_n) begin
            e_fsync <= '1; e_fcnt <= f_load(fb_mod); e_ftog <= 1'b0;
        end else begin
            e_fsync <= {e_fsync[SYNC-2:0], hold_ctl | pwr_hold};
            if (e_fsync[SYNC-1]) begin
                e_fcnt <= f_load(fb_mod); e_ftog <= 1'b0;
            end else if (e_fcnt == '0) begin
                e_fcnt <= f_load(fb_mod); e_ftog <= ~e_ftog;
            end else e_fcnt <= e_fcnt - 1'b1;
        end
    end

    // Per-cycle comparison 2 ns after each domain's rising edge.
    always begin
        @(posedge ref_clk); #2;
        if (chk_en) begin
            chk("R1", "ref_tc", ref_tc, (!e_rsync[SYNC-1] && e_rcnt == '0));
            chk("R4", "ref_half", ref_half, e_rtog);
            chk("R8", "mon_out", mon_out, f_mon(mon_sel, e_rtog, e_ftog));
        end
    end

    always begin
        @(posedge fb_clk); #2;
        if (chk_en) begin
            chk("R1", "fb_tc", fb_tc, (!e_fsync[SYNC-1] && e_fcnt == '0));
            chk("R4", "fb_half", fb_half, e_ftog);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wait_ref_tc(output int n);
        n = 0;
        do begin @(posedge ref_clk); #2; n++; end while (!ref_tc && n < 400);
    endtask

    task automatic wait_fb_tc(output int n);
        n = 0;
        do begin @(posedge fb_clk); #2; n++; end while (!fb_tc && n < 400);
    endtask

    initial begin
        int n, n2, h, l;
        bit run;
        void'($urandom(32'd7151));

        // R9: reset state.
        step(10);
        @(posedge ref_clk); #2;
        chk("R9", "ref_tc in reset", ref_tc, 0);
        chk("R9", "ref_half in reset", ref_half, 0);
        chk("R9", "fb_tc in reset", fb_tc, 0);
        chk("R9", "mon_out in reset", mon_out, 0);
        @(negedge ref_clk);
        chk_en = 1'b1;

        // R5: software hold keeps both lanes idle after reset release.
        hold_ctl = 1'b1;
        step(1); rst_n = 1'b1;
        step(6);
        chk("R5", "ref_tc held", ref_tc, 0);
        chk("R5", "fb_tc held", fb_tc, 0);
        chk("R5", "fb_half held", fb_half, 0);

        // R7: first strobe after release at edge SYNC+M-1.
        hold_ctl = 1'b0;
        wait_ref_tc(n);
        chk("R7", "edges to first ref_tc", n, SYNC + 5 - 1);

        // R1: strobe spacing in both domains.
        wait_ref_tc(n);
        chk("R1", "ref_tc period M=5", n, 5);
        wait_fb_tc(n);
        wait_fb_tc(n);
        chk("R1", "fb_tc period M=3", n, 3);

        // R4: 50% duty on the half-rate output with M=3.
        @(negedge ref_clk); ref_mod = 8'd3;
        step(20);
        n = 0;
        do begin @(posedge ref_clk); #2; n++; end while (ref_half && n < 50);
        do begin @(posedge ref_clk); #2; n++; end while (!ref_half && n < 100);
        h = 1; run = 1'b1;
        while (run && h < 50) begin @(posedge ref_clk); #2; if (ref_half) h++; else run = 1'b0; end
        l = 1; run = 1'b1;
        while (run && l < 50) begin @(posedge ref_clk); #2; if (!ref_half) l++; else run = 1'b0; end
        chk("R4", "ref_half high cycles", h, 3);
        chk("R4", "ref_half low cycles", l, 3);

        // R3: modulus change mid-period applies at the next reload.
        @(negedge ref_clk); ref_mod = 8'd4;
        step(20);
        wait_ref_tc(n);
        @(posedge ref_clk); #2;
        @(negedge ref_clk); ref_mod = 8'd7;
        wait_ref_tc(n);
        chk("R3", "remaining old period", n + 1, 4);
        wait_ref_tc(n2);
        chk("R3", "new period", n2, 7);

        // R2: modulus 0 and 1 both strobe every cycle.
        @(negedge ref_clk); ref_mod = 8'd0;
        step(10);
        n = 0;
        for (int i = 0; i < 6; i++) begin @(posedge ref_clk); #2; n += ref_tc; end
        chk("R2", "ref_tc cycles high of 6, M=0", n, 6);
        @(negedge ref_clk); ref_mod = 8'd1;
        step(10);
        n = 0;
        for (int i = 0; i < 6; i++) begin @(posedge ref_clk); #2; n += ref_tc; end
        chk("R2", "ref_tc cycles high of 6, M=1", n, 6);

        // R6: power hold alone holds both lanes; then both holds together.
        @(negedge ref_clk); ref_mod = 8'd4; fb_mod = 8'd5;
        step(30);
        pwr_hold = 1'b1;
        step(5);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge ref_clk); #2; n += ref_tc + ref_half + fb_tc + fb_half;
        end
        chk("R6", "active outputs under power hold", n, 0);
        @(negedge ref_clk); hold_ctl = 1'b1; pwr_hold = 1'b0;
        step(5);
        @(posedge ref_clk); #2;
        chk("R5", "ref_half under software hold", ref_half, 0);
        @(negedge ref_clk); hold_ctl = 1'b0;
        wait_ref_tc(n);
        chk("R7", "edges to first ref_tc, M=4", n, SYNC + 4 - 1);

        // R8: monitor routing, directed.
        @(negedge ref_clk); mon_sel = 3'd1;
        step(3); #1;
        chk("R8", "sel=1 follows ref_half", mon_out, ref_half);
        @(negedge ref_clk); mon_sel = 3'd2; #1;
        chk("R8", "sel=2 follows fb_half", mon_out, fb_half);
        n = 0;
        @(negedge ref_clk); mon_sel = 3'd6;
        for (int i = 0; i < 20; i++) begin @(posedge ref_clk); #2; n += mon_out; end
        chk("R8", "sel=6 high cycles", n, 0);

        // Random mix, compared cycle by cycle against the expectation.
        for (int i = 0; i < 150; i++) begin
            @(negedge ref_clk);
            ref_mod  = 8'($urandom % 10);
            fb_mod   = 8'($urandom % 10);
            mon_sel  = 3'($urandom % 8);
            hold_ctl = (($urandom % 6) == 0);
            pwr_hold = (($urandom % 6) == 0);
            step(20);
        end

        // R9: reset while running returns lanes to the held state.
        @(negedge ref_clk); hold_ctl = 1'b0; pwr_hold = 1'b0; ref_mod = 8'd2;
        step(10);
        rst_n = 1'b0;
        step(4);
        chk("R9", "ref_half after reset", ref_half, 0);
        chk("R9", "fb_half after reset", fb_half, 0);
        chk("R9", "ref_tc after reset", ref_tc, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired before R1..R9 sequence ended actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule